// File: doc/BRIEF.md
# Multi-Link Token Bucket Policer

This block sits at the entry of a switch node and polices the frames of up to eight virtual links. Every link carries one unicast flow and owns a separate token bucket. For each frame, the upstream parser presents the link index and the frame length in bits. One cycle later the block pulses either a pass or a drop indication. A passing frame spends its length in credit. A dropped frame leaves the credit as it was.

The bucket of a link is not set up with free numbers. Software writes a link descriptor that holds three values: the maximum frame length, the minimum gap between frame starts (in clock ticks) and the admissible jitter (in clock ticks). A derivation state machine runs a serial divider and turns the descriptor into a refill rate and a bucket depth. It moves through four states:

- `D_IDLE` goes to `D_RATE` when it accepts a descriptor.
- `D_RATE` goes to `D_SIZE` when the rate quotient is complete.
- `D_SIZE` goes to `D_COMMIT` when the depth quotient is complete.
- `D_COMMIT` goes back to `D_IDLE` unconditionally, loading the new values into the link and refilling its bucket.

Credit is held in fixed point with 8 fractional bits, so rates that are not whole bits per tick still accumulate exactly.

Top module: `vl_policer`

## Requirements
- R1: Each link keeps its own credit and parameters. A frame on one link never changes the credit or the decisions of another link.
- R2: A descriptor (maxlen M, gap G, jitter J) gives the following values, in units of 1/256 bit: rate = floor(M*256/G) and depth = M*256 + floor(M*J*256/G).
- R3: On every clock edge without a load, the credit of each link grows by its rate and saturates at its depth.
- R4: A frame is conforming only if its length L is at most the link's maxlen and the credit is at least L*256. On conformance, `frm_pass` is high in the cycle after the frame. The credit then becomes min(credit - L*256 + rate, depth).
- R5: For a non-conforming frame, `frm_drop` is high in the cycle after the frame. The credit receives only the refill.
- R6: A frame longer than the link's maxlen is always dropped, even with a full bucket.
- R7: After reset, every link holds maxlen 12000, gap 1000 and jitter 500, its bucket is full, and all outputs are low.
- R8: A descriptor is accepted only when `cfg_busy` is low. `cfg_busy` then stays high for 79 cycles, which is 2*(14+16+8)+3. On the last of these edges the link takes the new values and its credit becomes the new depth. A frame decided on that same edge uses the old values, and its spend is overridden by the refill.
- R9: A descriptor presented while `cfg_busy` is high is ignored.
- R10: A gap of 0 is treated as a gap of 1.
- R11: `frm_pass` and `frm_drop` are never high together. Neither pulses in a cycle that did not follow a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Descriptor write strobe |
| cfg_link | input | 3 | Link index of the descriptor |
| cfg_maxlen | input | 14 | Maximum frame length in bits |
| cfg_gap | input | 16 | Minimum gap between frame starts, ticks |
| cfg_jitter | input | 16 | Admissible jitter, ticks |
| cfg_busy | output | 1 | Derivation in progress |
| frm_valid | input | 1 | Frame presented this cycle |
| frm_link | input | 3 | Link index of the frame |
| frm_len | input | 14 | Frame length in bits |
| frm_pass | output | 1 | Previous frame conformed |
| frm_drop | output | 1 | Previous frame is to be dropped |

## Verification
Two functions can meet on one edge: the commit of a new descriptor to a link and a conformance decision for a frame on that same link. The bench provokes this by presenting a frame on the reconfigured link in every cycle of the busy window, so that one frame lands exactly on the commit edge. The old maxlen is set well above the new one, so the edge is visible at the ports. A behavioural reference model judges the outcome: the decision on the commit edge must follow the old limits, and every later decision must see a freshly full bucket under the new limits.

// File: rtl/vl_pkg.sv
`timescale 1ns/1ps
package vl_pkg;
    localparam int FRAC_W = 8;

    typedef enum logic [1:0] {
        D_IDLE,
        D_RATE,
        D_SIZE,
        D_COMMIT
    } der_state_e;
endpackage

// File: rtl/vl_div.sv
`timescale 1ns/1ps
module vl_div #(
    parameter int NUM_W = 38,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_q, quo_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   rem_q, rem_sh, rem_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q, ge;

    always_comb begin
        rem_sh = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
        ge     = rem_sh >= {1'b0, den_q};
        rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            num_q  <= num;
            den_q  <= den;
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= CNT_W'(NUM_W);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            num_q <= {num_q[NUM_W-2:0], 1'b0};
            quo_q <= {quo_q[NUM_W-2:0], ge};
            rem_q <= rem_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
endmodule

// File: rtl/vl_derive.sv
`timescale 1ns/1ps
module vl_derive import vl_pkg::*; #(
    parameter int LINK_W = 3,
    parameter int LEN_W  = 14,
    parameter int GAP_W  = 16,
    parameter int JIT_W  = 16,
    parameter int RATE_W = LEN_W + FRAC_W,
    parameter int CRED_W = LEN_W + JIT_W + FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic [LEN_W-1:0]  cfg_maxlen,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [JIT_W-1:0]  cfg_jitter,
    output logic              busy,
    output logic              commit,
    output logic [LINK_W-1:0] commit_link,
    output logic [LEN_W-1:0]  new_maxlen,
    output logic [RATE_W-1:0] new_rate,
    output logic [CRED_W-1:0] new_size
);
    localparam int NUM_W  = LEN_W + JIT_W + FRAC_W;
    localparam int PROD_W = LEN_W + JIT_W;

    der_state_e st_q, st_d;

    logic [LINK_W-1:0] link_q;
    logic [LEN_W-1:0]  max_q;
    logic [GAP_W-1:0]  gap_q, gap_fix;
    logic [JIT_W-1:0]  jit_q;
    logic [RATE_W-1:0] rate_q;
    logic [CRED_W-1:0] size_q;
    logic [PROD_W-1:0] prod;

    logic              accept;
    logic              div_start, div_done;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [GAP_W-1:0]  div_den;

    assign accept  = (st_q == D_IDLE) && cfg_valid;
    assign gap_fix = (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;
    assign prod    = PROD_W'(max_q) * PROD_W'(jit_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_IDLE:   if (cfg_valid) st_d = D_RATE;
            D_RATE:   if (div_done)  st_d = D_SIZE;
            D_SIZE:   if (div_done)  st_d = D_COMMIT;
            D_COMMIT: st_d = D_IDLE;
            default:  st_d = D_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= D_IDLE;
        else        st_q <= st_d;
    end

    // outputs of the state machine
    always_comb begin
        busy      = 1'b1;
        commit    = 1'b0;
        div_start = 1'b0;
        div_num   = NUM_W'({prod, {FRAC_W{1'b0}}});
        div_den   = gap_q;
        unique case (st_q)
            D_IDLE: begin
                busy      = 1'b0;
                div_start = cfg_valid;
                div_num   = NUM_W'({cfg_maxlen, {FRAC_W{1'b0}}});
                div_den   = gap_fix;
            end
            D_RATE:   div_start = div_done;
            D_SIZE:   div_start = 1'b0;
            D_COMMIT: commit    = 1'b1;
            default:  busy      = 1'b1;
        endcase
    end

    // descriptor capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= '0;
            max_q  <= '0;
            gap_q  <= GAP_W'(1);
            jit_q  <= '0;
            rate_q <= '0;
            size_q <= '0;
        end else begin
            if (accept) begin
                link_q <= cfg_link;
                max_q  <= cfg_maxlen;
                gap_q  <= gap_fix;
                jit_q  <= cfg_jitter;
            end
            if (st_q == D_RATE && div_done)
                rate_q <= div_quo[RATE_W-1:0];
            if (st_q == D_SIZE && div_done)
                size_q <= CRED_W'({max_q, {FRAC_W{1'b0}}}) + CRED_W'(div_quo);
        end
    end

    vl_div #(.NUM_W(NUM_W), .DEN_W(GAP_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign commit_link = link_q;
    assign new_maxlen  = max_q;
    assign new_rate    = rate_q;
    assign new_size    = size_q;
endmodule

// File: rtl/vl_bucket.sv
`timescale 1ns/1ps
module vl_bucket import vl_pkg::*; #(
    parameter int               LEN_W    = 14,
    parameter int               RATE_W   = 22,
    parameter int               CRED_W   = 39,
    parameter logic [LEN_W-1:0]  RST_MAX  = '0,
    parameter logic [RATE_W-1:0] RST_RATE = '0,
    parameter logic [CRED_W-1:0] RST_SIZE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  new_maxlen,
    input  logic [RATE_W-1:0] new_rate,
    input  logic [CRED_W-1:0] new_size,
    input  logic              hit,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              conform,
    output logic [CRED_W-1:0] credit,
    output logic [CRED_W-1:0] size,
    output logic [LEN_W-1:0]  maxlen
);
    logic [CRED_W-1:0] cred_q, size_q, len_fx, spend;
    logic [RATE_W-1:0] rate_q;
    logic [LEN_W-1:0]  max_q;
    logic [CRED_W:0]   sum;

    always_comb begin
        len_fx  = CRED_W'({frm_len, {FRAC_W{1'b0}}});
        conform = (frm_len <= max_q) && (cred_q >= len_fx);
        spend   = (hit && conform) ? len_fx : '0;
        sum     = {1'b0, cred_q} - {1'b0, spend} + (CRED_W+1)'(rate_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= RST_SIZE;
            size_q <= RST_SIZE;
            rate_q <= RST_RATE;
            max_q  <= RST_MAX;
        end else if (load) begin
            cred_q <= new_size;
            size_q <= new_size;
            rate_q <= new_rate;
            max_q  <= new_maxlen;
        end else begin
            cred_q <= (sum > {1'b0, size_q}) ? size_q : sum[CRED_W-1:0];
        end
    end

    assign credit = cred_q;
    assign size   = size_q;
    assign maxlen = max_q;
endmodule

// File: rtl/vl_policer.sv
`timescale 1ns/1ps
module vl_policer import vl_pkg::*; #(
    parameter int NUM_LINKS  = 8,
    parameter int LEN_W      = 14,
    parameter int GAP_W      = 16,
    parameter int JIT_W      = 16,
    parameter int DEF_MAXLEN = 12000,
    parameter int DEF_GAP    = 1000,
    parameter int DEF_JIT    = 500,
    localparam int LINK_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic [LEN_W-1:0]  cfg_maxlen,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [JIT_W-1:0]  cfg_jitter,
    output logic              cfg_busy,
    input  logic              frm_valid,
    input  logic [LINK_W-1:0] frm_link,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_pass,
    output logic              frm_drop
);
    localparam int RATE_W = LEN_W + FRAC_W;
    localparam int CRED_W = LEN_W + JIT_W + FRAC_W + 1;
    localparam int SLOTS  = 1 << LINK_W;

    localparam longint L_MAXFX = longint'(DEF_MAXLEN) << FRAC_W;
    localparam longint L_RATE  = L_MAXFX / longint'(DEF_GAP);
    localparam longint L_SIZE  = L_MAXFX +
        ((longint'(DEF_MAXLEN) * longint'(DEF_JIT)) << FRAC_W) / longint'(DEF_GAP);

    logic              commit;
    logic [LINK_W-1:0] commit_link;
    logic [LEN_W-1:0]  new_maxlen;
    logic [RATE_W-1:0] new_rate;
    logic [CRED_W-1:0] new_size;

    logic [NUM_LINKS-1:0]             conform;
    logic [SLOTS-1:0]                 conf_all;
    logic [NUM_LINKS-1:0][CRED_W-1:0] lk_cred;
    logic [NUM_LINKS-1:0][CRED_W-1:0] lk_size;
    logic [NUM_LINKS-1:0][LEN_W-1:0]  lk_max;
    logic                             pass_q, drop_q;

    vl_derive #(
        .LINK_W (LINK_W),
        .LEN_W  (LEN_W),
        .GAP_W  (GAP_W),
        .JIT_W  (JIT_W),
        .RATE_W (RATE_W),
        .CRED_W (CRED_W)
    ) i_derive (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .cfg_link    (cfg_link),
        .cfg_maxlen  (cfg_maxlen),
        .cfg_gap     (cfg_gap),
        .cfg_jitter  (cfg_jitter),
        .busy        (cfg_busy),
        .commit      (commit),
        .commit_link (commit_link),
        .new_maxlen  (new_maxlen),
        .new_rate    (new_rate),
        .new_size    (new_size)
    );

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        logic load_i, hit_i;
        assign load_i = commit && (commit_link == LINK_W'(i));
        assign hit_i  = frm_valid && (frm_link == LINK_W'(i));

        vl_bucket #(
            .LEN_W    (LEN_W),
            .RATE_W   (RATE_W),
            .CRED_W   (CRED_W),
            .RST_MAX  (LEN_W'(DEF_MAXLEN)),
            .RST_RATE (RATE_W'(L_RATE)),
            .RST_SIZE (CRED_W'(L_SIZE))
        ) i_bucket (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_i),
            .new_maxlen (new_maxlen),
            .new_rate   (new_rate),
            .new_size   (new_size),
            .hit        (hit_i),
            .frm_len    (frm_len),
            .conform    (conform[i]),
            .credit     (lk_cred[i]),
            .size       (lk_size[i]),
            .maxlen     (lk_max[i])
        );
    end

    always_comb begin
        conf_all                = '0;
        conf_all[NUM_LINKS-1:0] = conform;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            pass_q <= frm_valid &&  conf_all[frm_link];
            drop_q <= frm_valid && !conf_all[frm_link];
        end
    end

    assign frm_pass = pass_q;
    assign frm_drop = drop_q;
endmodule

// File: rtl/vl_policer_chk.sv
`timescale 1ns/1ps
module vl_policer_chk #(
    parameter int NUM_LINKS = 8,
    parameter int LINK_W    = 3,
    parameter int LEN_W     = 14,
    parameter int CRED_W    = 39
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cfg_valid,
    input logic                             cfg_busy,
    input logic                             frm_valid,
    input logic [LINK_W-1:0]                frm_link,
    input logic [LEN_W-1:0]                 frm_len,
    input logic                             frm_pass,
    input logic                             frm_drop,
    input logic [NUM_LINKS-1:0][LEN_W-1:0]  lk_max,
    input logic [NUM_LINKS-1:0][CRED_W-1:0] lk_cred,
    input logic [NUM_LINKS-1:0][CRED_W-1:0] lk_size
);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_pass && frm_drop));

    a_r11_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !(frm_pass || frm_drop));

    a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (frm_pass || frm_drop));

    a_r6_long_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_len > lk_max[frm_link])) |=> frm_drop);

    a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_busy) |=> cfg_busy);

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_cap
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            lk_cred[g] <= lk_size[g]);
    end
endmodule

bind vl_policer vl_policer_chk #(
    .NUM_LINKS (NUM_LINKS),
    .LINK_W    (LINK_W),
    .LEN_W     (LEN_W),
    .CRED_W    (CRED_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_busy  (cfg_busy),
    .frm_valid (frm_valid),
    .frm_link  (frm_link),
    .frm_len   (frm_len),
    .frm_pass  (frm_pass),
    .frm_drop  (frm_drop),
    .lk_max    (lk_max),
    .lk_cred   (lk_cred),
    .lk_size   (lk_size)
);

// File: tb/test_vl_policer.sv
`timescale 1ns/1ps
module test_vl_policer;
    localparam int NL  = 8;
    localparam int FR  = 8;
    localparam int LAT = 2 * (14 + 16 + 8) + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_link = '0;
    logic [13:0] cfg_maxlen = '0;
    logic [15:0] cfg_gap = '0;
    logic [15:0] cfg_jitter = '0;
    logic        cfg_busy;
    logic        frm_valid = 1'b0;
    logic [2:0]  frm_link = '0;
    logic [13:0] frm_len = '0;
    logic        frm_pass, frm_drop;

    int total = 0;
    int bad   = 0;

    // reference model state
    longint m_cred[NL], m_rate[NL], m_size[NL], m_max[NL];
    int     m_left = 0;
    int     p_lnk  = 0;
    longint p_rate, p_size, p_max;

    always #2.5 clk = ~clk;

    vl_policer i_vl_policer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_link   (cfg_link),
        .cfg_maxlen (cfg_maxlen),
        .cfg_gap    (cfg_gap),
        .cfg_jitter (cfg_jitter),
        .cfg_busy   (cfg_busy),
        .frm_valid  (frm_valid),
        .frm_link   (frm_link),
        .frm_len    (frm_len),
        .frm_pass   (frm_pass),
        .frm_drop   (frm_drop)
    );

    function automatic void model_reset();
        for (int i = 0; i < NL; i++) begin
            m_max[i]  = 12000;
            m_rate[i] = (longint'(12000) << FR) / 1000;
            m_size[i] = (longint'(12000) << FR) + ((longint'(12000) * 500) << FR) / 1000;
            m_cred[i] = m_size[i];
        end
        m_left = 0;
    endfunction

    // one clock: drive, predict, advance, compare
    task automatic step(input bit fv, input int fl, input int flen,
                        input bit cv, input int cl, input int cm, input int cg, input int cj,
                        input string tag);
        bit ep, ed, eb, commit_now;
        longint lfx, g;
        frm_valid  = fv;
        frm_link   = 3'(fl);
        frm_len    = 14'(flen);
        cfg_valid  = cv;
        cfg_link   = 3'(cl);
        cfg_maxlen = 14'(cm);
        cfg_gap    = 16'(cg);
        cfg_jitter = 16'(cj);
        ep = 1'b0;
        ed = 1'b0;
        lfx = longint'(flen) << FR;
        if (fv) begin
            if (flen <= m_max[fl] && m_cred[fl] >= lfx) ep = 1'b1;
            else ed = 1'b1;
        end
        commit_now = (m_left == 1);
        for (int i = 0; i < NL; i++) begin
            if (commit_now && i == p_lnk) begin
                m_max[i]  = p_max;
                m_rate[i] = p_rate;
                m_size[i] = p_size;
                m_cred[i] = p_size;
            end else begin
                m_cred[i] = m_cred[i] - ((fv && ep && fl == i) ? lfx : 0) + m_rate[i];
                if (m_cred[i] > m_size[i]) m_cred[i] = m_size[i];
            end
        end
        if (m_left > 0) m_left--;
        else if (cv) begin
            g      = (cg == 0) ? 1 : cg;
            p_lnk  = cl;
            p_max  = cm;
            p_rate = (longint'(cm) << FR) / g;
            p_size = (longint'(cm) << FR) + ((longint'(cm) * cj) << FR) / g;
            m_left = LAT;
        end
        eb = (m_left > 0);
        @(posedge clk);
        @(negedge clk);
        total++;
        if (frm_pass !== ep || frm_drop !== ed || cfg_busy !== eb) begin
            bad++;
            $display("FAIL %s t=%0t actual pass=%b drop=%b busy=%b expected pass=%b drop=%b busy=%b",
                     tag, $time, frm_pass, frm_drop, cfg_busy, ep, ed, eb);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic frame(input int fl, input int flen, input string tag);
        step(1, fl, flen, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic configure(input int cl, input int cm, input int cg, input int cj, input string tag);
        step(0, 0, 0, 1, cl, cm, cg, cj, tag);
        idle(LAT, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state: outputs low, defaults in force
        idle(3, "R7 reset outputs");
        frame(0, 12000, "R7 default maxlen fits full bucket");
        frame(7, 12000, "R7 default on last link");
        frame(0, 12001, "R6 over default maxlen");
        frame(0, 6000, "R4 remaining default credit");

        // R2 derivation, R9 write while busy ignored
        step(0, 0, 0, 1, 1, 100, 10, 20, "R2 descriptor accept");
        idle(10, "R8 busy window");
        step(0, 0, 0, 1, 1, 5, 1, 1, "R9 write while busy");
        idle(LAT - 11, "R8 busy window");
        idle(2, "R8 after commit");
        // R3 saturation at depth 300 bits, R4/R5 spend and drop
        for (int k = 0; k < 5; k++) frame(1, 100, "R3 R4 R5 burst on capped bucket");
        idle(40, "R3 refill");
        frame(1, 101, "R6 over maxlen with full bucket");
        frame(1, 100, "R9 old descriptor still in force");
        frame(1, 6, "R9 len above ignored maxlen");

        // R8 commit and frame on the same edge
        step(1, 3, 60, 1, 3, 50, 10, 0, "R8 accept with frame");
        for (int k = 0; k < LAT + 3; k++) frame(3, 60, "R8 frame around commit edge");
        frame(3, 50, "R8 new maxlen");
        frame(3, 50, "R8 new depth");

        // R10 gap zero acts as one
        configure(2, 40, 0, 0, "R10 gap zero");
        for (int k = 0; k < 6; k++) frame(2, 40, "R10 refill equals maxlen");
        frame(2, 41, "R10 R6 over maxlen");

        // R2 fractional rate
        configure(6, 100, 3, 5, "R2 fractional rate");
        for (int k = 0; k < 30; k++) frame(6, 100, "R2 fractional refill pattern");

        // R1 independence
        configure(4, 100, 10, 20, "R1 link a");
        configure(5, 100, 10, 20, "R1 link b");
        for (int k = 0; k < 5; k++) frame(4, 100, "R1 drain link a");
        for (int k = 0; k < 3; k++) frame(5, 100, "R1 link b untouched");
        for (int k = 0; k < 6; k++) begin
            frame(4, 30, "R1 interleave a");
            frame(5, 30, "R1 interleave b");
        end
        idle(5, "R11 quiet outputs");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule